// File: doc/BRIEF.md
# Ping-Pong Pixel Sample Demultiplexer

This block receives one stream of pixel samples, one per cycle of a fast sampling clock. Each sample has three 8-bit colour channels. The block splits the stream into two output ports that run at half the sampling rate. Samples alternate between the ports: the earlier sample of each pair goes to port A, and the sample that follows it goes to port B. Both ports change on the same clock edge, and each value then stays put for two sampling periods. A receiving device can therefore capture the pair with a slower clock.

Port A runs one cycle longer in the pipeline than port B, and this is what lines the two samples of a pair up on one edge. The block also produces a half-rate clock that goes high on every port update, together with its complement. It passes the full-rate sampling clock through as well, again with its complement. A capturing device should latch both ports on the falling edge of the half-rate clock, or on the rising edge of its complement.

Top module: `pixel_pingpong_demux`

## Requirements
- R1: A sample is 24 bits wide, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each port carries all three channels in the same bit positions as the input.
- R2: Port A presents each even-indexed sample (index 0 is the first sample taken after reset) starting 3 sampling-clock edges after the edge that takes that sample.
- R3: Port B presents each odd-indexed sample starting 2 sampling-clock edges after the edge that takes that sample. This is the same edge on which port A shows the sample just before it.
- R4: Ports A and B change only on alternate sampling edges, always together. Between two updates each port holds its value for exactly two sampling periods.
- R5: The half-rate clock output goes high on every edge that updates the ports and goes low on the edge after it, so it toggles on every sampling edge once reset is released. Its complement output is always the inverse.
- R6: The full-rate clock output equals the sampling clock, and its complement output equals the inverted sampling clock.
- R7: While the synchronous active-low reset is sampled low, both ports clear to zero and the half-rate clock output is low. After reset is released, the first sample taken is numbered 0, goes to port A, and no sample taken before or during reset ever appears on a port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock; one sample is taken per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_i | input | 24 | Incoming pixel sample {red, green, blue} |
| clk_full_o | output | 1 | Copy of the sampling clock |
| clk_full_n_o | output | 1 | Inverted copy of the sampling clock |
| clk_half_o | output | 1 | Half-rate clock; goes high on each port update |
| clk_half_n_o | output | 1 | Inverse of the half-rate clock |
| port_a_o | output | 24 | Earlier sample of each pair |
| port_b_o | output | 24 | Later sample of each pair |

## Verification
The assertions check on every cycle that the half-rate clock toggles and rises whenever the port data changes. They also check that neither port moves between updates, and that after each update port A equals the input from four edges earlier and port B the input from three. Only the bench's scenarios can show that numbering restarts correctly after a reset in the middle of a stream. The same holds for the claim that samples taken before or during reset never leak out, and for the claim that each colour field keeps its bit position on random data as well as on all-zero and all-one patterns.

// File: rtl/pixel_pingpong_pkg.sv
// Package: shared widths and types for the ping-pong pixel demultiplexer.
// Assumes three colour channels of equal width, packed red-high to blue-low.
package pixel_pingpong_pkg;
    localparam int CH_W  = 8;
    localparam int N_CH  = 3;
    localparam int PIX_W = CH_W * N_CH;

    typedef logic [PIX_W-1:0] pix_t;

    // Position of each channel inside a packed sample
    typedef enum logic [1:0] {
        CH_BLUE  = 2'd0,
        CH_GREEN = 2'd1,
        CH_RED   = 2'd2
    } chan_e;
endpackage

// File: rtl/px_phase_gen.sv
// Module: px_phase_gen
// Generates the A/B pair phase and the half-rate clock output.
// Assumes every sampling edge carries a valid sample. The phase is 0 on the
// edge that takes an even sample and 1 on the edge that takes an odd sample.
// The ports update on phase-1 edges, and the half-rate clock rises there.
module px_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o,
    output logic half_o
);
    logic phase_q;
    logic half_q;

    // Phase toggles every sampling edge; reset restarts on the even phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    // Half-rate clock: goes high on the update edge, low on the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= phase_q;
        end
    end

    assign phase_o = phase_q;
    assign half_o  = half_q;

    // Once out of reset for a cycle, the phase alternates on every edge
    p_phase_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase_q != $past(phase_q)));

    // Half-rate clock toggles on every edge after the first post-reset edge
    p_half_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (half_q != $past(half_q)));
endmodule

// File: rtl/px_lane_split.sv
// Module: px_lane_split
// Registers the incoming sample, then steers it into the even or the odd
// holding lane, one channel slice at a time.
// Assumes the load strobes come from px_phase_gen: even_ld on phase-1 edges
// (the captured sample is even) and odd_ld on phase-0 edges (the captured
// sample is odd). The even lane is thus one stage deeper than the odd lane.
module px_lane_split #(
    parameter int CH_W = 8,
    parameter int N_CH = 3,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] smp_i,
    input  logic             even_ld,
    input  logic             odd_ld,
    output logic [PIX_W-1:0] even_o,
    output logic [PIX_W-1:0] odd_o
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int LO = c * CH_W;

        logic [CH_W-1:0] cap_q;
        logic [CH_W-1:0] ev_q;
        logic [CH_W-1:0] od_q;

        // Capture stage: takes one channel slice of the input every edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_q <= '0;
            end else begin
                cap_q <= smp_i[LO +: CH_W];
            end
        end

        // Even lane: keeps the earlier sample of the pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ev_q <= '0;
            end else if (even_ld) begin
                ev_q <= cap_q;
            end
        end

        // Odd lane: keeps the later sample of the pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                od_q <= '0;
            end else if (odd_ld) begin
                od_q <= cap_q;
            end
        end

        assign even_o[LO +: CH_W] = ev_q;
        assign odd_o[LO +: CH_W]  = od_q;
    end
endmodule

// File: rtl/px_port_out.sv
// Module: px_port_out
// Output registers for both ports. Both load on the same update strobe, so
// the even/odd pair appears together and stays for two sampling periods.
// Assumes upd_i is high on every other edge.
module px_port_out #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] port_a_o,
    output logic [PIX_W-1:0] port_b_o
);
    logic [PIX_W-1:0] a_q;
    logic [PIX_W-1:0] b_q;

    // Port registers: clear on reset, load the aligned pair on update edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (upd_i) begin
            a_q <= a_i;
            b_q <= b_i;
        end
    end

    assign port_a_o = a_q;
    assign port_b_o = b_q;

    // Ports stay unchanged across any edge without an update strobe
    p_port_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/pixel_pingpong_demux.sv
// Module: pixel_pingpong_demux (top)
// Splits a full-rate stream of three-channel pixel samples into two
// half-rate ports. Port A holds the even sample and port B the odd sample of
// each pair, with latencies of three and two edges. Also drives the half-rate
// clock pair and a pass-through of the sampling clock pair.
// Assumes every sampling edge carries a valid sample; reset is synchronous
// and active low.
module pixel_pingpong_demux #(
    parameter int CH_W = pixel_pingpong_pkg::CH_W,
    parameter int N_CH = pixel_pingpong_pkg::N_CH,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] smp_i,
    output logic             clk_full_o,
    output logic             clk_full_n_o,
    output logic             clk_half_o,
    output logic             clk_half_n_o,
    output logic [PIX_W-1:0] port_a_o,
    output logic [PIX_W-1:0] port_b_o
);
    logic             phase;
    logic             half;
    logic [PIX_W-1:0] even_lane;
    logic [PIX_W-1:0] odd_lane;

    // Pair phase and half-rate clock
    px_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .half_o  (half)
    );

    // Capture and lane steering
    px_lane_split #(
        .CH_W (CH_W),
        .N_CH (N_CH)
    ) u_split (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_i   (smp_i),
        .even_ld (phase),
        .odd_ld  (~phase),
        .even_o  (even_lane),
        .odd_o   (odd_lane)
    );

    // Aligned port registers
    px_port_out #(
        .PIX_W (PIX_W)
    ) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (phase),
        .a_i      (even_lane),
        .b_i      (odd_lane),
        .port_a_o (port_a_o),
        .port_b_o (port_b_o)
    );

    // Clock outputs: pass-through pair and half-rate pair
    assign clk_full_o   = clk;
    assign clk_full_n_o = ~clk;
    assign clk_half_o   = half;
    assign clk_half_n_o = ~half;

    // After an update, port A holds the input from four edges back
    p_lat_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_half_o) && $past(rst_n) && $past(rst_n, 2) &&
         $past(rst_n, 3) && $past(rst_n, 4))
        |-> (port_a_o == $past(smp_i, 4)));

    // After an update, port B holds the input from three edges back
    p_lat_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_half_o) && $past(rst_n) && $past(rst_n, 2) &&
         $past(rst_n, 3) && $past(rst_n, 4))
        |-> (port_b_o == $past(smp_i, 3)));

    // Port data only moves together with a rising half-rate clock
    p_move_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((port_a_o != $past(port_a_o)) ||
                          (port_b_o != $past(port_b_o))))
        |-> $rose(clk_half_o));

    // The edge after reset leaves both ports cleared and the half clock low
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (port_a_o == '0 && port_b_o == '0 && !clk_half_o));
endmodule

// File: tb/pixel_pingpong_demux_bench.sv
module pixel_pingpong_demux_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] smp = '0;
    logic        clk_full, clk_full_n, clk_half, clk_half_n;
    logic [23:0] port_a, port_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [23:0] s [0:63];

    always #5 clk = ~clk;

    pixel_pingpong_demux u_pixel_pingpong_demux (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_i        (smp),
        .clk_full_o   (clk_full),
        .clk_full_n_o (clk_full_n),
        .clk_half_o   (clk_half),
        .clk_half_n_o (clk_half_n),
        .port_a_o     (port_a),
        .port_b_o     (port_b)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected port A after post-reset edge e (sample e taken at edge e)
    function automatic logic [23:0] exp_a(input int e);
        int u;
        if (e < 3) return '0;
        u = (e % 2 == 1) ? e : e - 1;
        return s[u-3];
    endfunction

    function automatic logic [23:0] exp_b(input int e);
        int u;
        if (e < 3) return '0;
        u = (e % 2 == 1) ? e : e - 1;
        return s[u-2];
    endfunction

    // Runs n edges out of reset on the samples in s, checking each edge
    task automatic run_stream(input int n, input bit chan_check);
        @(negedge clk);
        rst_n = 1'b1;
        smp   = s[0];
        for (int e = 0; e < n; e++) begin
            @(posedge clk);
            #1;
            if (e == 0) begin
                chk("R6 full clock high", {23'd0, clk_full}, 24'd1);
                chk("R6 full clock complement", {23'd0, clk_full_n}, 24'd0);
            end
            @(negedge clk);
            chk("R2 port A", port_a, exp_a(e));
            chk("R3 port B", port_b, exp_b(e));
            chk("R5 half clock", {23'd0, clk_half}, {23'd0, (e % 2 == 1)});
            chk("R5 half complement", {23'd0, clk_half_n}, {23'd0, (e % 2 == 0)});
            if (e >= 3 && e % 2 == 0) begin
                // R4: second period of a hold, both ports unchanged
                chk("R4 hold A", port_a, exp_a(e - 1));
                chk("R4 hold B", port_b, exp_b(e - 1));
            end
            if (chan_check && e >= 3) begin
                chk("R1 red field", {16'd0, port_a[23:16]}, {16'd0, exp_a(e) >> 16});
                chk("R1 green field", {16'd0, port_b[15:8]}, {16'd0, exp_b(e)[15:8]});
                chk("R1 blue field", {16'd0, port_a[7:0]}, {16'd0, exp_a(e)[7:0]});
            end
            if (e == 0) begin
                chk("R6 full clock low", {23'd0, clk_full}, 24'd0);
                chk("R6 full complement high", {23'd0, clk_full_n}, 24'd1);
            end
            smp = (e + 1 < 64) ? s[e+1] : '0;
        end
    endtask

    // Holds reset for k edges with random input, checking the cleared state
    task automatic do_reset(input int k);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < k; i++) begin
            smp = $urandom;
            @(posedge clk);
            @(negedge clk);
            chk("R7 reset port A", port_a, '0);
            chk("R7 reset port B", port_b, '0);
            chk("R7 reset half clock", {23'd0, clk_half}, '0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(3);

        // Directed: distinct channel patterns, all-zero and all-one samples
        for (int i = 0; i < 64; i++)
            s[i] = {8'(i * 3 + 1), 8'(~i), 8'(i ^ 8'h5A)};
        s[4] = 24'hFFFFFF;
        s[5] = 24'h000000;
        s[6] = 24'h000000;
        s[7] = 24'hFFFFFF;
        s[8] = 24'hFF0000;
        s[9] = 24'h00FF00;
        run_stream(16, 1'b1);

        // Random stream
        do_reset(2);
        for (int i = 0; i < 64; i++) s[i] = $urandom;
        run_stream(40, 1'b1);

        // Mid-stream reset after an odd number of edges: numbering restarts
        do_reset(1);
        for (int i = 0; i < 64; i++) s[i] = $urandom;
        run_stream(7, 1'b0);
        do_reset(2);
        for (int i = 0; i < 64; i++) s[i] = $urandom;
        run_stream(12, 1'b0);
        // R7: first pair after the mid-stream reset came from samples 0 and 1
        // (checked inside run_stream at edges 3 and 4 by exp_a/exp_b)

        // Random stream with long run
        do_reset(1);
        for (int i = 0; i < 64; i++) s[i] = $urandom;
        run_stream(60, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule